// File: doc/BRIEF.md
# DMA Interrupt Synchronization Gate

This block sits beside one DMA channel and decides when the channel's transfer engine may begin a read cycle and when it may begin a write cycle. It watches a vector of interrupt lines. Two select inputs name the line that paces the read (source) side and the line that paces the write (destination) side. A rising edge on a selected line is remembered in a per-side latch. The engine consumes that latch when it starts the matching cycle. The channel's control word is also held here. Its two-bit sync-mode field picks which sides are paced, and its two-bit start field says whether the channel is idle, paused between transfers, or running.

Edges are remembered whenever the start field is anything but idle (`00`). An interrupt that arrives before the channel runs, or while it is paused after a transfer, is therefore honoured once the channel runs again. Each capture is reported on a per-line acknowledge pulse in the same cycle, so the interrupt flag logic can clear the pending flag at that moment rather than when the engine later uses the event. A single edge on a line that paces both sides releases a read and a write together. Several instances can watch the same lines, and each captures independently.

Top module: `dma_sync_gate`

## Requirements
- R1: While the start field is `00`, interrupt edges are neither latched nor acknowledged: `irq_ack` stays zero, and no permit is released after the field later becomes `11`.
- R2: While the start field is `01`, `10` or `11`, a rising edge on the selected line of a paced side sets that side's latch on the next clock, so an edge seen while paused or before running releases the permit once the field is `11`.
- R3: A high `dma_rst` at a clock edge clears both latches and sets the start field and sync mode to `00`. It takes priority over a control write and over `xfer_done`, and no capture happens in that cycle.
- R4: A control write (`ctl_we`) loads the start field from `ctl_wdata[1:0]` and the sync mode from `ctl_wdata[7:6]`. Otherwise, `xfer_done` while the start field is `11` changes it to `10` on the next clock. In every other state `xfer_done` leaves the start field unchanged.
- R5: Sync mode `00` paces neither side, `01` paces reads only, `10` paces writes only, and `11` paces both. A side that is not paced has its permit equal to "start field is `11`".
- R6: `rd_permit` and `wr_permit` are low whenever the start field is not `11`. A paced side's permit is high when the start field is `11` and its latch is set.
- R7: When `rd_sel` equals `wr_sel` and both sides are paced, one rising edge sets both latches.
- R8: `irq_ack[i]` is high in exactly the cycle in which an edge on line i is captured by at least one side. It is never high for a line that no paced side selects.
- R9: Interrupt inputs are edge-detected. A line held high yields one capture and one acknowledge pulse, never pulses on consecutive cycles.
- R10: `rd_begin` while `rd_permit` is high on a paced read side clears the read latch on the next clock, and `wr_begin` does the same for the write side. If a new edge is captured in the same cycle, the latch stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_rst | input | 1 | Synchronous channel reset; clears the latches and the control word |
| irq_in | input | NUM_IRQ | Interrupt lines, level inputs, edge-detected inside |
| rd_sel | input | SEL_W | Index of the line that paces read cycles |
| wr_sel | input | SEL_W | Index of the line that paces write cycles |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: [7:6] sync mode, [1:0] start field |
| xfer_done | input | 1 | Transfer completed pulse from the engine |
| rd_begin | input | 1 | Engine starts a read cycle |
| wr_begin | input | 1 | Engine starts a write cycle |
| rd_permit | output | 1 | Read cycle may begin |
| wr_permit | output | 1 | Write cycle may begin |
| irq_ack | output | NUM_IRQ | One-cycle acknowledge per captured line |
| start_q | output | 2 | Current start field |

## Verification
Directed sequences apply edges in each start state: idle, paused and running. They separate "ignored while idle" from "remembered while paused" by switching the channel to running afterwards and reading the permits. A shared select line with both sides paced shows whether one edge feeds both latches. A held-high line shows whether the input is edge- or level-sensitive. An edge that coincides with a begin strobe shows whether capture wins over consumption. Random traffic then mixes line toggles, begin strobes, control writes, completions and channel resets across all four sync modes. It is compared cycle by cycle with a bench model of the latches and the control word.

// File: rtl/dma_sync_pkg.sv
package dma_sync_pkg;

  typedef enum logic [1:0] {
    SYNC_NONE = 2'b00,
    SYNC_SRC  = 2'b01,
    SYNC_DST  = 2'b10,
    SYNC_BOTH = 2'b11
  } sync_mode_e;

  localparam logic [1:0] START_IDLE   = 2'b00;
  localparam logic [1:0] START_PAUSED = 2'b10;
  localparam logic [1:0] START_RUN    = 2'b11;

  // read side is paced by the low mode bit
  function automatic logic paces_read(input sync_mode_e m);
    return (m == SYNC_SRC) || (m == SYNC_BOTH);
  endfunction

  // write side is paced by the high mode bit
  function automatic logic paces_write(input sync_mode_e m);
    return (m == SYNC_DST) || (m == SYNC_BOTH);
  endfunction

  // latching happens in every start state except idle
  function automatic logic is_armed(input logic [1:0] st);
    return st != START_IDLE;
  endfunction

  function automatic logic is_running(input logic [1:0] st);
    return st == START_RUN;
  endfunction

  // next start field after a completion strobe
  function automatic logic [1:0] after_done(input logic [1:0] st);
    return (st == START_RUN) ? START_PAUSED : st;
  endfunction

endpackage

// File: rtl/dma_sync_edge.sv
module dma_sync_edge #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic [NUM_IRQ-1:0] irq_prev,
  output logic [NUM_IRQ-1:0] irq_rise
);

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_prev[i] <= 1'b0;
      else        irq_prev[i] <= irq_in[i];
    end
    assign irq_rise[i] = irq_in[i] & ~irq_prev[i];
  end

endmodule

// File: rtl/dma_sync_ctl.sv
module dma_sync_ctl
  import dma_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dma_rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       xfer_done,
  output logic [1:0] start_q,
  output sync_mode_e mode_q
);

  localparam int MODE_LO = 6;
  localparam int MODE_HI = 7;

  logic unused_ctl_bits;
  assign unused_ctl_bits = ^ctl_wdata[5:2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= START_IDLE;
      mode_q  <= SYNC_NONE;
    end else if (dma_rst) begin
      start_q <= START_IDLE;
      mode_q  <= SYNC_NONE;
    end else if (ctl_we) begin
      start_q <= ctl_wdata[1:0];
      mode_q  <= sync_mode_e'(ctl_wdata[MODE_HI:MODE_LO]);
    end else if (xfer_done) begin
      start_q <= after_done(start_q);
    end
  end

endmodule

// File: rtl/dma_sync_side.sv
module dma_sync_side (
  input  logic clk,
  input  logic rst_n,
  input  logic dma_rst,
  input  logic paced,
  input  logic armed,
  input  logic running,
  input  logic edge_hit,
  input  logic begin_i,
  output logic pend_o,
  output logic permit_o,
  output logic capture_o,
  output logic consume_o
);

  logic pend_n;

  assign capture_o = armed & paced & edge_hit & ~dma_rst;
  assign permit_o  = running & (~paced | pend_o);
  assign consume_o = begin_i & permit_o & paced;

  // capture has priority over consumption in the same cycle
  always_comb begin
    pend_n = pend_o;
    if (consume_o) pend_n = 1'b0;
    if (capture_o) pend_n = 1'b1;
    if (dma_rst)   pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_n;
  end

endmodule

// File: rtl/dma_sync_gate.sv
module dma_sync_gate
  import dma_sync_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  localparam int SEL_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_rst,
  input  logic [NUM_IRQ-1:0] irq_in,
  input  logic [SEL_W-1:0]   rd_sel,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic               ctl_we,
  input  logic [7:0]         ctl_wdata,
  input  logic               xfer_done,
  input  logic               rd_begin,
  input  logic               wr_begin,
  output logic               rd_permit,
  output logic               wr_permit,
  output logic [NUM_IRQ-1:0] irq_ack,
  output logic [1:0]         start_q
);

  sync_mode_e         mode_q;
  logic [NUM_IRQ-1:0] irq_prev;
  logic [NUM_IRQ-1:0] irq_rise;
  logic               armed;
  logic               running;
  logic               rd_paced;
  logic               wr_paced;
  logic               rd_pend;
  logic               wr_pend;
  logic               rd_capture;
  logic               wr_capture;
  logic               rd_consume;
  logic               wr_consume;

  dma_sync_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_rst   (dma_rst),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .xfer_done (xfer_done),
    .start_q   (start_q),
    .mode_q    (mode_q)
  );

  dma_sync_edge #(.NUM_IRQ(NUM_IRQ)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_in   (irq_in),
    .irq_prev (irq_prev),
    .irq_rise (irq_rise)
  );

  assign armed    = is_armed(start_q);
  assign running  = is_running(start_q);
  assign rd_paced = paces_read(mode_q);
  assign wr_paced = paces_write(mode_q);

  dma_sync_side u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_rst   (dma_rst),
    .paced     (rd_paced),
    .armed     (armed),
    .running   (running),
    .edge_hit  (irq_rise[rd_sel]),
    .begin_i   (rd_begin),
    .pend_o    (rd_pend),
    .permit_o  (rd_permit),
    .capture_o (rd_capture),
    .consume_o (rd_consume)
  );

  dma_sync_side u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_rst   (dma_rst),
    .paced     (wr_paced),
    .armed     (armed),
    .running   (running),
    .edge_hit  (irq_rise[wr_sel]),
    .begin_i   (wr_begin),
    .pend_o    (wr_pend),
    .permit_o  (wr_permit),
    .capture_o (wr_capture),
    .consume_o (wr_consume)
  );

  // acknowledge goes to every line that some side captured this cycle
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_ack
    assign irq_ack[i] = (rd_capture && (rd_sel == SEL_W'(i))) ||
                        (wr_capture && (wr_sel == SEL_W'(i)));
  end

endmodule

// File: rtl/dma_sync_gate_chk.sv
module dma_sync_gate_chk #(
  parameter int NUM_IRQ = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dma_rst,
  input logic               ctl_we,
  input logic               xfer_done,
  input logic [NUM_IRQ-1:0] irq_ack,
  input logic               rd_permit,
  input logic               wr_permit,
  input logic [1:0]         start_q,
  input logic               rd_pend,
  input logic               wr_pend,
  input logic               rd_capture,
  input logic               wr_capture
);

  assert_idle_no_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q == 2'b00) |-> (irq_ack == '0));

  assert_rd_capture_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> rd_pend);

  assert_wr_capture_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_capture |=> wr_pend);

  assert_chan_reset_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rst |=> (start_q == 2'b00 && !rd_pend && !wr_pend));

  assert_done_pauses_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q == 2'b11 && xfer_done && !ctl_we && !dma_rst) |=> (start_q == 2'b10));

  assert_permit_only_running_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q != 2'b11) |-> (!rd_permit && !wr_permit));

  assert_ack_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_ack) |=> ((irq_ack & $past(irq_ack)) == '0));

endmodule

bind dma_sync_gate dma_sync_gate_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dma_rst    (dma_rst),
  .ctl_we     (ctl_we),
  .xfer_done  (xfer_done),
  .irq_ack    (irq_ack),
  .rd_permit  (rd_permit),
  .wr_permit  (wr_permit),
  .start_q    (start_q),
  .rd_pend    (rd_pend),
  .wr_pend    (wr_pend),
  .rd_capture (rd_capture),
  .wr_capture (wr_capture)
);

// File: tb/sim_dma_sync_gate.sv
`timescale 1ns/100ps
module sim_dma_sync_gate;

  localparam int NI = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dma_rst = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [SW-1:0] rd_sel = '0;
  logic [SW-1:0] wr_sel = '0;
  logic          ctl_we = 1'b0;
  logic [7:0]    ctl_wdata = '0;
  logic          xfer_done = 1'b0;
  logic          rd_begin = 1'b0;
  logic          wr_begin = 1'b0;
  logic          rd_permit, wr_permit;
  logic [NI-1:0] irq_ack;
  logic [1:0]    start_q;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model state
  logic [1:0]    m_start = 2'b00;
  logic [1:0]    m_mode = 2'b00;
  logic          m_rdp = 1'b0;
  logic          m_wrp = 1'b0;
  logic [NI-1:0] m_prev = '0;

  always #2.5 clk = ~clk;

  dma_sync_gate #(.NUM_IRQ(NI)) u0 (
    .clk(clk), .rst_n(rst_n), .dma_rst(dma_rst), .irq_in(irq_in),
    .rd_sel(rd_sel), .wr_sel(wr_sel), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .xfer_done(xfer_done), .rd_begin(rd_begin), .wr_begin(wr_begin),
    .rd_permit(rd_permit), .wr_permit(wr_permit), .irq_ack(irq_ack),
    .start_q(start_q)
  );

  function automatic logic exp_rd_permit();
    if (m_start != 2'b11) return 1'b0;
    return m_mode[0] ? m_rdp : 1'b1;
  endfunction

  function automatic logic exp_wr_permit();
    if (m_start != 2'b11) return 1'b0;
    return m_mode[1] ? m_wrp : 1'b1;
  endfunction

  function automatic logic exp_rd_cap();
    logic [NI-1:0] rise = irq_in & ~m_prev;
    return (m_start != 2'b00) && !dma_rst && m_mode[0] && rise[rd_sel];
  endfunction

  function automatic logic exp_wr_cap();
    logic [NI-1:0] rise = irq_in & ~m_prev;
    return (m_start != 2'b00) && !dma_rst && m_mode[1] && rise[wr_sel];
  endfunction

  function automatic logic [NI-1:0] exp_ack();
    logic [NI-1:0] a = '0;
    if (exp_rd_cap()) a[rd_sel] = 1'b1;
    if (exp_wr_cap()) a[wr_sel] = 1'b1;
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare all outputs with the model, then advance one clock
  task automatic step(input string tag);
    logic rc, wc;
    #1;
    chk({tag, " rd_permit"}, 32'(rd_permit), 32'(exp_rd_permit()));
    chk({tag, " wr_permit"}, 32'(wr_permit), 32'(exp_wr_permit()));
    chk({tag, " irq_ack"},   32'(irq_ack),   32'(exp_ack()));
    chk({tag, " start"},     32'(start_q),   32'(m_start));
    rc = exp_rd_cap();
    wc = exp_wr_cap();
    @(posedge clk);
    if (dma_rst) begin
      m_rdp = 1'b0; m_wrp = 1'b0;
    end else begin
      if (rc) m_rdp = 1'b1;
      else if (rd_begin && exp_rd_permit() && m_mode[0]) m_rdp = 1'b0;
      if (wc) m_wrp = 1'b1;
      else if (wr_begin && exp_wr_permit() && m_mode[1]) m_wrp = 1'b0;
    end
    if (dma_rst) begin
      m_start = 2'b00; m_mode = 2'b00;
    end else if (ctl_we) begin
      m_start = ctl_wdata[1:0]; m_mode = ctl_wdata[7:6];
    end else if (xfer_done && m_start == 2'b11) begin
      m_start = 2'b10;
    end
    m_prev = irq_in;
    @(negedge clk);
    ctl_we = 1'b0; xfer_done = 1'b0; dma_rst = 1'b0;
    rd_begin = 1'b0; wr_begin = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] w, input string tag);
    ctl_we = 1'b1; ctl_wdata = w;
    step(tag);
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    #1;
    chk("R6 reset rd_permit", 32'(rd_permit), 32'd0);
    chk("R6 reset wr_permit", 32'(wr_permit), 32'd0);
    chk("R4 reset start", 32'(start_q), 32'd0);
    chk("R8 reset ack", 32'(irq_ack), 32'd0);
    @(negedge clk);

    // R1: mode both, start idle; edge on line 2 is ignored
    rd_sel = 3'd2; wr_sel = 3'd2;
    wr_ctl(8'hC0, "R4 load idle");
    irq_in[2] = 1'b1; step("R1 idle edge");
    irq_in[2] = 1'b0; step("R1 idle low");
    wr_ctl(8'hC3, "R4 load run");
    #1;
    chk("R1 no permit after idle edge rd", 32'(rd_permit), 32'd0);
    chk("R1 no permit after idle edge wr", 32'(wr_permit), 32'd0);

    // R2/R7/R8/R9: paused, shared line captured once by both sides
    wr_ctl(8'hC2, "R4 load paused");
    irq_in[2] = 1'b1;
    #1;
    chk("R8 ack on capture", 32'(irq_ack), 32'h04);
    step("R7 shared edge");
    #1;
    chk("R9 held level no second ack", 32'(irq_ack), 32'h00);
    step("R9 held level");
    wr_ctl(8'hC3, "R2 resume run");
    #1;
    chk("R2 paused edge honoured rd", 32'(rd_permit), 32'd1);
    chk("R7 one edge opens write", 32'(wr_permit), 32'd1);

    // R10: consume read; then edge and write begin in the same cycle
    rd_begin = 1'b1; step("R10 read consume");
    #1;
    chk("R10 read latch consumed", 32'(rd_permit), 32'd0);
    chk("R10 write latch untouched", 32'(wr_permit), 32'd1);
    irq_in[2] = 1'b0; step("R10 low");
    irq_in[2] = 1'b1; wr_begin = 1'b1; step("R10 edge with consume");
    #1;
    chk("R10 new edge stays latched", 32'(wr_permit), 32'd1);

    // R4/R6: completion pauses the channel
    xfer_done = 1'b1; step("R4 done");
    #1;
    chk("R4 done gives paused", 32'(start_q), 32'h2);
    chk("R6 paused no permit", 32'(wr_permit), 32'd0);
    xfer_done = 1'b1; step("R4 done while paused");

    // R3: channel reset clears latches even with a control write
    dma_rst = 1'b1; ctl_we = 1'b1; ctl_wdata = 8'hC3; step("R3 reset");
    #1;
    chk("R3 start cleared", 32'(start_q), 32'd0);
    wr_ctl(8'hC3, "R3 rerun");
    #1;
    chk("R3 latches cleared", 32'({rd_permit, wr_permit}), 32'd0);

    // R5: mode encodings
    wr_ctl(8'h03, "R5 mode none");
    #1;
    chk("R5 none permits", 32'({rd_permit, wr_permit}), 32'h3);
    wr_ctl(8'h43, "R5 mode src");
    #1;
    chk("R5 src gates read only", 32'({rd_permit, wr_permit}), 32'h1);
    wr_ctl(8'h83, "R5 mode dst");
    #1;
    chk("R5 dst gates write only", 32'({rd_permit, wr_permit}), 32'h2);
    irq_in = '0; step("R8 settle");
    irq_in[5] = 1'b1; rd_sel = 3'd5; wr_sel = 3'd1;
    #1;
    chk("R8 no ack for unpaced side", 32'(irq_ack), 32'h00);
    step("R8 unpaced");

    // random traffic across all modes and states
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < NI; b++)
        if ($urandom_range(0, 5) == 0) irq_in[b] = ~irq_in[b];
      if ($urandom_range(0, 15) == 0) rd_sel = SW'($urandom_range(0, NI-1));
      if ($urandom_range(0, 15) == 0) wr_sel = SW'($urandom_range(0, NI-1));
      if ($urandom_range(0, 19) == 0) begin
        ctl_we = 1'b1;
        ctl_wdata = 8'($urandom_range(0, 255));
        if ($urandom_range(0, 1) == 1) ctl_wdata[1:0] = 2'b11;
      end
      xfer_done = ($urandom_range(0, 24) == 0);
      dma_rst   = ($urandom_range(0, 199) == 0);
      rd_begin  = ($urandom_range(0, 2) == 0);
      wr_begin  = ($urandom_range(0, 2) == 0);
      step("R2/R5/R6/R10 random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule